// File: doc/BRIEF.md
# Three-Entry Operand Stack Datapath

This block is the integer execution datapath of a small stack-oriented processor core. Three 32-bit registers act as a shallow last-in first-out stack. The top entry is called A, the next entry B and the bottom entry C. Operations take their operands from the top of this stack and put their result back on top, so instructions need no register specifiers. The stack has no overflow or underflow detection. A push drops whatever was in C, and any entry that is vacated at the bottom holds an unspecified value.

A controller issues one operation at a time over a valid/ready handshake, with a 4-bit operation code. A push takes its value from `load_data`. A pop returns the old top entry on `store_data`, together with a one-cycle `store_valid` pulse. The logic operations, arithmetic operations and barrel shifts all finish in the cycle in which they are accepted. A multiply takes a fixed three cycles. During those cycles `op_ready` is low, and the stack does not change until the product is written. The two top entries are always visible on `top_a` and `top_b`, so the controller can branch on them.

Top module: `evs_stack`

## Requirements
- R1: After a synchronous active-low reset, `top_a` and `top_b` are zero, `op_ready` is high and `store_valid` is low.
- R2: An accepted push (code 1) sets A to `load_data`, B to the old A and C to the old B. The old C is lost.
- R3: An accepted pop (code 2) drives the old A on `store_data` with `store_valid` high for exactly the next cycle. It also moves B into A and C into B. C is then unspecified.
- R4: Codes 3 to 7 (add, subtract, and, or, xor) compute f(B, A), for example B minus A for subtract. The result is written into A, C moves into B, and the result is visible one clock after acceptance.
- R5: Code 8 shifts B left by A and code 9 shifts B right logically by A. Each takes a single cycle for any amount, and an amount of 32 or more gives zero. The result goes to A and C moves into B.
- R6: Code 10 multiplies B by A and keeps the low 32 bits. The product appears in A, with C moved into B, exactly three clocks after the edge that accepted it.
- R7: While a multiply is in progress, `op_ready` is low, any offered operation is ignored, and A and B hold their values.
- R8: Code 0 and the unused codes 11 to 15 are accepted and leave the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The datapath can accept an operation |
| op_code | input | 4 | Operation code |
| load_data | input | 32 | Value for a push |
| store_data | output | 32 | Value removed by the last pop |
| store_valid | output | 1 | `store_data` holds a new value this cycle |
| top_a | output | 32 | Top entry A |
| top_b | output | 32 | Second entry B |

## Verification
The assertions assume that the controller keeps `op_code` and `load_data` meaningful whenever `op_valid` is high. They also assume that an operation accepted during a multiply is not expected to take effect, so a request held through a busy period is legally dropped. The stimulus drives every request on the falling edge. It holds each request for exactly one edge while `op_ready` is high. During a multiply, it deliberately offers a push to show that the push is refused. The bench never compares an entry that has become unspecified after a pop or an operation. It tracks which model entries are defined and compares B only when it is.

// File: rtl/evs_pkg.sv
// Package: operation codes shared by the operand stack datapath and its bench.
package evs_pkg;
    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_PUSH = 4'd1,
        OP_POP  = 4'd2,
        OP_ADD  = 4'd3,
        OP_SUB  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_MUL  = 4'd10
    } evs_op_e;
endpackage

// File: rtl/evs_shifter.sv
// Module: evs_shifter
// Combinational logarithmic barrel shifter. It shifts `val` left or right
// (logical) by `amt`. Any amount at or above W yields zero.
// Assumes W is a power of two.
module evs_shifter #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] amt,
    input  logic         left,
    output logic [W-1:0] res
);
    localparam int SW = $clog2(W);

    logic [W-1:0] stage [SW+1];
    logic         too_far;

    assign stage[0] = val;

    // One stage per amount bit; stage i shifts by 2**i when its bit is set.
    for (genvar i = 0; i < SW; i++) begin : g_stage
        always_comb begin
            if (!amt[i])
                stage[i+1] = stage[i];
            else if (left)
                stage[i+1] = stage[i] << (1 << i);
            else
                stage[i+1] = stage[i] >> (1 << i);
        end
    end

    // Amount of W or more flushes every bit out.
    assign too_far = |amt[W-1:SW];
    assign res     = too_far ? '0 : stage[SW];

    // R5: a zero amount must pass the operand through untouched.
    always_comb begin
        if (amt == '0)
            a_r5_zero_shift: assert (res == val);
    end
endmodule

// File: rtl/evs_multiplier.sv
// Module: evs_multiplier
// Fixed-latency multiplier. It latches both operands on `start` and raises
// `done` in the cycle before the LAT-th edge after that start, so the
// product can be written on that edge. Only the low W bits are kept.
// Assumes LAT >= 2 and that `start` is never raised while busy.
module evs_multiplier #(
    parameter int W   = 32,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] product
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  ra, rb;

    // Track the cycles of a multiply in flight and latch its operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            ra   <= '0;
            rb   <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            ra   <= opa;
            rb   <= opb;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done    = busy && (cnt == CW'(LAT - 1));
    assign product = W'(ra * rb);

    // R6: a started multiply is busy on the next cycle and ends once done.
    a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/evs_stack.sv
// Module: evs_stack
// Three-entry operand stack (A on top, then B, then C) with single-cycle
// ALU and shift operations and a fixed-latency multiply. There is no
// depth checking: a push discards C, and a consuming operation clears C
// to zero, which callers must treat as unspecified.
// Assumes op_code and load_data are stable while op_valid is high.
module evs_stack
    import evs_pkg::*;
#(
    parameter int W       = 32,
    parameter int MUL_LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    output logic         op_ready,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] store_data,
    output logic         store_valid,
    output logic [W-1:0] top_a,
    output logic [W-1:0] top_b
);
    localparam logic [W-1:0] C_VOID = '0;

    evs_op_e      op;
    logic         fire, mul_start, mul_busy, mul_done;
    logic [W-1:0] a_q, b_q, c_q;
    logic [W-1:0] sh_res, mul_res, alu_res;
    logic         alu_op;

    assign op        = evs_op_e'(op_code);
    assign op_ready  = !mul_busy;
    assign fire      = op_valid && op_ready;
    assign mul_start = fire && (op == OP_MUL);

    evs_shifter #(.W(W)) u_shift (
        .val  (b_q),
        .amt  (a_q),
        .left (op == OP_SHL),
        .res  (sh_res)
    );

    evs_multiplier #(.W(W), .LAT(MUL_LAT)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mul_start),
        .opa     (b_q),
        .opb     (a_q),
        .busy    (mul_busy),
        .done    (mul_done),
        .product (mul_res)
    );

    // Select the single-cycle result of a consuming operation: f(B, A).
    always_comb begin
        alu_op  = 1'b1;
        alu_res = '0;
        case (op)
            OP_ADD:  alu_res = b_q + a_q;
            OP_SUB:  alu_res = b_q - a_q;
            OP_AND:  alu_res = b_q & a_q;
            OP_OR:   alu_res = b_q | a_q;
            OP_XOR:  alu_res = b_q ^ a_q;
            OP_SHL,
            OP_SHR:  alu_res = sh_res;
            default: alu_op = 1'b0;
        endcase
    end

    // Update the three stack entries for push, pop, operations and multiply completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            c_q <= '0;
        end else if (mul_done) begin
            a_q <= mul_res;
            b_q <= c_q;
            c_q <= C_VOID;
        end else if (fire) begin
            if (op == OP_PUSH) begin
                a_q <= load_data;
                b_q <= a_q;
                c_q <= b_q;
            end else if (op == OP_POP) begin
                a_q <= b_q;
                b_q <= c_q;
                c_q <= C_VOID;
            end else if (alu_op) begin
                a_q <= alu_res;
                b_q <= c_q;
                c_q <= C_VOID;
            end
        end
    end

    // Present the popped top entry with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_valid <= 1'b0;
            store_data  <= '0;
        end else begin
            store_valid <= fire && (op == OP_POP);
            if (fire && (op == OP_POP))
                store_data <= a_q;
        end
    end

    assign top_a = a_q;
    assign top_b = b_q;

    // R2: a push lands the load value on top and shifts the old top down.
    a_r2_push_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_PUSH) |=> (a_q == $past(load_data) && b_q == $past(a_q)));
    // R3: a pop presents the old top for exactly one cycle.
    a_r3_pop_store: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_POP) |=> (store_valid && store_data == $past(a_q)));
    a_r3_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
        store_valid |=> !store_valid || $past(fire && op == OP_POP));
    // R7: an accepted multiply closes the handshake on the next cycle.
    a_r7_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |=> !op_ready);
    // R7: the stack holds still while a multiply is pending.
    a_r7_hold_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_ready && !mul_done) |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: tb/evs_stack_test.sv
// Directed bench for evs_stack with a three-entry reference model.
module evs_stack_test;
    import evs_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] load_data = '0;
    logic        op_ready, store_valid;
    logic [31:0] store_data, top_a, top_b;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Reference model entries and their defined flags.
    logic [31:0] ma = 0, mb = 0, mc = 0;
    bit va = 1, vb = 1, vc = 1;

    always #10 clk = ~clk;

    evs_stack uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_code(op_code), .load_data(load_data), .store_data(store_data),
        .store_valid(store_valid), .top_a(top_a), .top_b(top_b)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_top(input string tag);
        chk(tag, top_a, ma);
        if (vb) chk(tag, top_b, mb);
    endtask

    // Drive one operation for one edge; model is updated by the caller.
    task automatic issue(input logic [3:0] c, input logic [31:0] d);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; load_data = d;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic m_push(input logic [31:0] d);
        mc = mb; vc = vb; mb = ma; vb = va; ma = d; va = 1;
    endtask

    task automatic m_consume(input logic [31:0] r);
        ma = r; va = 1; mb = mc; vb = vc; vc = 0;
    endtask

    task automatic t_reset;
        chk("R1 top_a", top_a, 32'h0);
        chk("R1 top_b", top_b, 32'h0);
        chk("R1 ready", {31'b0, op_ready}, 32'h1);
        chk("R1 store_valid", {31'b0, store_valid}, 32'h0);
    endtask

    task automatic t_push_overflow;
        for (int i = 1; i <= 4; i++) begin
            issue(OP_PUSH, 32'h100 * i);
            m_push(32'h100 * i);
            chk_top("R2 push");
        end
        // C now holds 0x200; 0x100 was dropped.
        issue(OP_POP, 0);
        chk("R3 store_data", store_data, 32'h400);
        chk("R3 store_valid", {31'b0, store_valid}, 32'h1);
        ma = mb; mb = mc; vb = vc; vc = 0;
        chk_top("R3 pop");
        @(negedge clk);
        chk("R3 strobe one cycle", {31'b0, store_valid}, 32'h0);
        issue(OP_POP, 0);
        chk("R2 overflow dropped", store_data, 32'h300);
        ma = mb; va = vb; vb = 0;
        chk("R2 second from bottom", top_a, 32'h200);
    endtask

    task automatic t_alu;
        logic [31:0] x, y;
        logic [31:0] r;
        for (int k = 0; k < 5; k++) begin
            x = 32'h9000_0005 + k * 32'h1357;
            y = 32'h0000_00F3 ^ (k * 32'h0F0F_0F0F);
            issue(OP_PUSH, x); m_push(x);
            issue(OP_PUSH, y); m_push(y);
            case (k)
                0: r = x + y;
                1: r = x - y;
                2: r = x & y;
                3: r = x | y;
                default: r = x ^ y;
            endcase
            issue(4'(3 + k), 0);
            m_consume(r);
            chk_top("R4 alu");
        end
    endtask

    task automatic t_shift;
        logic [31:0] amts [5] = '{0, 1, 31, 32, 40};
        for (int k = 0; k < 5; k++) begin
            for (int d = 0; d < 2; d++) begin
                logic [31:0] v, r;
                v = 32'hC3A5_0F81;
                if (d == 0) r = (amts[k] >= 32) ? 0 : v << amts[k];
                else        r = (amts[k] >= 32) ? 0 : v >> amts[k];
                issue(OP_PUSH, v); m_push(v);
                issue(OP_PUSH, amts[k]); m_push(amts[k]);
                issue(d == 0 ? OP_SHL : OP_SHR, 0);
                m_consume(r);
                chk_top("R5 shift");
            end
        end
    endtask

    task automatic t_mul(input logic [31:0] x, input logic [31:0] y);
        logic [31:0] olda;
        issue(OP_PUSH, 32'h77); m_push(32'h77);
        issue(OP_PUSH, x); m_push(x);
        issue(OP_PUSH, y); m_push(y);
        olda = ma;
        @(negedge clk);
        op_valid = 1'b1; op_code = OP_MUL;
        @(negedge clk);
        chk("R7 ready low", {31'b0, op_ready}, 32'h0);
        chk("R7 A held", top_a, olda);
        op_code = OP_PUSH; load_data = 32'hDEAD_BEEF;
        @(negedge clk);
        chk("R7 ready low 2", {31'b0, op_ready}, 32'h0);
        chk("R7 push ignored", top_a, olda);
        @(negedge clk);
        chk("R6 not early", top_a, olda);
        op_valid = 1'b0;
        @(negedge clk);
        m_consume(32'(x * y));
        chk("R6 ready back", {31'b0, op_ready}, 32'h1);
        chk_top("R6 product");
    endtask

    task automatic t_nop;
        issue(OP_PUSH, 32'h55); m_push(32'h55);
        issue(OP_PUSH, 32'hAA); m_push(32'hAA);
        issue(OP_NOP, 32'h1234);
        chk_top("R8 nop");
        issue(4'd15, 32'h1234);
        chk_top("R8 unused code");
        issue(4'd11, 32'h1234);
        chk_top("R8 unused code 11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_overflow();
        t_alu();
        t_shift();
        t_mul(32'd1234, 32'd5678);
        t_mul(32'hFFFF_FFFF, 32'h8000_0003);
        t_nop();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule